// File: doc/BRIEF.md
# Color Line Aligner with Odd/Even Pixel Merge

This block sits after the digitizers of a three-color linear image sensor. Each color row is read out as two parallel sample streams, one carrying the odd-numbered pixels and one the even-numbered pixels, and both arrive in the same clock cycle. The block captures one such odd/even pair per color together and turns each pair into two consecutive output samples, in natural pixel order. A region code from the sensor timing generator marks which pairs belong to the active photocell window. Pairs from any other region are thrown away.

The three color rows sit a fixed number of scan lines apart on the die. A document line therefore reaches the first row first, the middle row `LINE_GAP` lines later, and the last row `2*LINE_GAP` lines later. The block buffers the first row for `2*LINE_GAP` whole lines and the middle row for `LINE_GAP` lines. The last row goes straight through. As a result, the red, green and blue values of one document line leave the block in the same cycle, with a line-start flag and a valid flag.

A direction input chooses which outer row is first. This allows scanning in either direction. The line length and the row gap are parameters, so short lines can be used in simulation. The merged stream runs at twice the pair rate, so valid pairs must be separated by at least one idle cycle.

Top module: `color_line_aligner`

## Requirements
- R1: Once the buffers are full, the odd sample of a captured active pair appears on the outputs one clock edge after the capture edge. Its even partner follows in the next cycle. Pixel order within a line is therefore 1, 2, 3, and so on.
- R2: Only pairs whose `region` equals 2'b10 (active) produce output samples. Pairs with codes 2'b00 (dummy), 2'b01 (optical black) and 2'b11 (invalid) are dropped and do not disturb the stream.
- R3: Two `pair_vld` cycles are never adjacent. At least one idle cycle separates consecutive pairs.
- R4: With `dir` = 0, the output green value comes from `LINE_GAP` sensor lines after the output red value, and the output blue value from `2*LINE_GAP` lines after it. All three carry the same pixel number.
- R5: With `dir` = 1, the roles of red and blue swap. Blue is the row taken `2*LINE_GAP` lines earliest, and red the latest.
- R6: After reset, `out_vld` stays low until `2*LINE_GAP*LINE_PIX` merged samples have entered. The first valid output carries the sample that follows them. All outputs read zero during reset.
- R7: `out_sol` is high exactly with the first pixel of each output line, and never without `out_vld`.
- R8: Any change of `dir` empties the alignment. `out_vld` is low from the next cycle until `2*LINE_GAP*LINE_PIX` further merged samples have entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dir | input | 1 | Scan direction: 0 means red row leads, 1 means blue row leads |
| pair_vld | input | 1 | One odd/even pair for all colors is present |
| region | input | 2 | Position code of the pair: 00 dummy, 01 black, 10 active, 11 invalid |
| red_odd | input | 16 | Red odd-pixel sample |
| red_even | input | 16 | Red even-pixel sample |
| grn_odd | input | 16 | Green odd-pixel sample |
| grn_even | input | 16 | Green even-pixel sample |
| blu_odd | input | 16 | Blue odd-pixel sample |
| blu_even | input | 16 | Blue even-pixel sample |
| out_vld | output | 1 | Aligned RGB pixel valid |
| out_sol | output | 1 | First pixel of an aligned line |
| out_r | output | 16 | Aligned red sample |
| out_g | output | 16 | Aligned green sample |
| out_b | output | 16 | Aligned blue sample |

## Verification
Each sample is tagged with its color, sensor line and pixel number, so every output reveals where it came from. Several kinds of error then show up as wrong tags or wrong counts:
- an off-by-one line delay,
- swapped odd/even order,
- a color routed to the wrong buffer for one direction,
- dummy, black or invalid pairs leaking into the stream, which shift the pixel number and inflate the output count.

The bench checks the output count to catch a fill counter that opens one sample early or late. An early opening would emit a sample from a not-yet-written buffer slot. A late opening would drop the first aligned pixel. The bench flips `dir` in mid-run and checks that nothing is emitted for the next `2*LINE_GAP` lines. A design that kept running would emit colors mixed from both directions. One exact-cycle check pins the two-register latency of the odd sample.

// File: rtl/lal_pkg.sv
`timescale 1ns/1ps
package lal_pkg;
    localparam int SAMPLE_W = 16;
    localparam int N_LANES  = 3;

    typedef enum logic [1:0] {
        RG_DUMMY   = 2'b00,
        RG_BLACK   = 2'b01,
        RG_ACTIVE  = 2'b10,
        RG_INVALID = 2'b11
    } region_e;

    typedef logic [SAMPLE_W-1:0] sample_t;

    typedef struct packed {
        sample_t r;
        sample_t g;
        sample_t b;
    } rgb_t;

    // Delay in samples for lane k: lane 0 leads, lane 2 trails
    function automatic int lane_depth(int lane, int gap, int pix);
        return (N_LANES - 1 - lane) * gap * pix;
    endfunction
endpackage

// File: rtl/lal_pair_merge.sv
`timescale 1ns/1ps
module lal_pair_merge
    import lal_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    pair_vld,
    input  region_e region,
    input  rgb_t    odd_pix,
    input  rgb_t    even_pix,
    output logic    m_vld,
    output logic    m_sol,
    output rgb_t    m_pix
);
    logic pend_q;
    logic run_q;
    rgb_t hold_q;
    logic accept;

    assign accept = pair_vld && (region == RG_ACTIVE);

    always_ff @(posedge clk) begin
        if (rst) begin
            m_vld  <= 1'b0;
            m_sol  <= 1'b0;
            m_pix  <= '0;
            hold_q <= '0;
            pend_q <= 1'b0;
            run_q  <= 1'b0;
        end else begin
            if (accept) begin
                m_vld  <= 1'b1;
                m_pix  <= odd_pix;
                hold_q <= even_pix;
                pend_q <= 1'b1;
                m_sol  <= !run_q;
            end else if (pend_q) begin
                m_vld  <= 1'b1;
                m_pix  <= hold_q;
                pend_q <= 1'b0;
                m_sol  <= 1'b0;
            end else begin
                m_vld  <= 1'b0;
                m_sol  <= 1'b0;
            end
            if (pair_vld) begin
                run_q <= accept;
            end
        end
    end

    // R3: pairs never arrive while an even sample is still pending
    p_pair_spacing_r3: assert property (@(posedge clk) disable iff (rst)
        pair_vld |-> !pend_q);

    // R1: an odd sample is always followed by its even partner
    p_even_follows_odd_r1: assert property (@(posedge clk) disable iff (rst)
        (m_vld && pend_q) |=> (m_vld && !pend_q && !m_sol));

    // R2: a non-active pair never starts an output pair
    p_drop_inactive_r2: assert property (@(posedge clk) disable iff (rst)
        (pair_vld && region != RG_ACTIVE) |=> !pend_q);
endmodule

// File: rtl/lal_line_delay.sv
`timescale 1ns/1ps
module lal_line_delay
    import lal_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    en,
    input  sample_t din,
    output sample_t dout
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    sample_t        mem [DEPTH];
    logic [AW-1:0]  ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (en) begin
            ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (en) begin
            mem[ptr] <= din;
        end
    end

    // Slot at ptr holds the sample written DEPTH enables ago
    assign dout = mem[ptr];
endmodule

// File: rtl/lal_fill_gate.sv
`timescale 1ns/1ps
module lal_fill_gate #(
    parameter int FILL = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic tick,
    output logic filled
);
    localparam int CW = $clog2(FILL + 1);
    localparam logic [CW-1:0] TOP = CW'(FILL);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt <= '0;
        end else if (tick && cnt != TOP) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign filled = (cnt == TOP);

    // R8: a restart empties the gate
    p_restart_clears_r8: assert property (@(posedge clk) disable iff (rst)
        restart |=> !filled);
endmodule

// File: rtl/color_line_aligner.sv
`timescale 1ns/1ps
module color_line_aligner
    import lal_pkg::*;
#(
    parameter int LINE_PIX = 64,
    parameter int LINE_GAP = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                dir,
    input  logic                pair_vld,
    input  logic [1:0]          region,
    input  logic [SAMPLE_W-1:0] red_odd,
    input  logic [SAMPLE_W-1:0] red_even,
    input  logic [SAMPLE_W-1:0] grn_odd,
    input  logic [SAMPLE_W-1:0] grn_even,
    input  logic [SAMPLE_W-1:0] blu_odd,
    input  logic [SAMPLE_W-1:0] blu_even,
    output logic                out_vld,
    output logic                out_sol,
    output logic [SAMPLE_W-1:0] out_r,
    output logic [SAMPLE_W-1:0] out_g,
    output logic [SAMPLE_W-1:0] out_b
);
    localparam int FILL_SAMPLES = lane_depth(0, LINE_GAP, LINE_PIX);

    rgb_t    odd_pix, even_pix, m_pix;
    logic    m_vld, m_sol;
    logic    dir_q, restart, filled;
    sample_t lane_in  [N_LANES];
    sample_t lane_out [N_LANES];

    assign odd_pix  = '{r: red_odd,  g: grn_odd,  b: blu_odd};
    assign even_pix = '{r: red_even, g: grn_even, b: blu_even};

    lal_pair_merge u_merge (
        .clk      (clk),
        .rst      (rst),
        .pair_vld (pair_vld),
        .region   (region_e'(region)),
        .odd_pix  (odd_pix),
        .even_pix (even_pix),
        .m_vld    (m_vld),
        .m_sol    (m_sol),
        .m_pix    (m_pix)
    );

    always_ff @(posedge clk) begin
        dir_q <= dir;
    end
    assign restart = !rst && (dir != dir_q);

    lal_fill_gate #(.FILL(FILL_SAMPLES)) u_fill (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .tick    (m_vld),
        .filled  (filled)
    );

    // Lane 0 leads (longest delay), lane 1 middle, lane 2 trails
    assign lane_in[0] = dir ? m_pix.b : m_pix.r;
    assign lane_in[1] = m_pix.g;
    assign lane_in[2] = dir ? m_pix.r : m_pix.b;

    for (genvar k = 0; k < N_LANES; k++) begin : g_lane
        localparam int D = lane_depth(k, LINE_GAP, LINE_PIX);
        if (D > 0) begin : g_buf
            lal_line_delay #(.DEPTH(D)) u_dly (
                .clk  (clk),
                .rst  (rst),
                .en   (m_vld),
                .din  (lane_in[k]),
                .dout (lane_out[k])
            );
        end else begin : g_thru
            assign lane_out[k] = lane_in[k];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld <= 1'b0;
            out_sol <= 1'b0;
            out_r   <= '0;
            out_g   <= '0;
            out_b   <= '0;
        end else begin
            out_vld <= m_vld && filled && !restart;
            out_sol <= m_sol && filled && !restart;
            out_r   <= dir ? lane_out[2] : lane_out[0];
            out_g   <= lane_out[1];
            out_b   <= dir ? lane_out[0] : lane_out[2];
        end
    end

    // R7: line start only on a valid pixel
    p_sol_with_vld_r7: assert property (@(posedge clk) disable iff (rst)
        out_sol |-> out_vld);

    // R6: nothing valid right after reset
    p_reset_blank_r6: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !out_vld);

    // R8: a direction change blanks the output
    p_restart_blank_r8: assert property (@(posedge clk) disable iff (rst)
        restart |=> !out_vld);
endmodule

// File: tb/test_color_line_aligner.sv
`timescale 1ns/1ps
module test_color_line_aligner;
    localparam int L   = 8;
    localparam int G   = 4;
    localparam int LAG = 2 * G;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        dir = 1'b0;
    logic        pair_vld = 1'b0;
    logic [1:0]  region = 2'b00;
    logic [15:0] red_odd = '0, red_even = '0, grn_odd = '0, grn_even = '0, blu_odd = '0, blu_even = '0;
    logic        out_vld, out_sol;
    logic [15:0] out_r, out_g, out_b;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int cap_cyc = -100;
    int mon_idx = 0;
    bit lat_done = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    color_line_aligner #(.LINE_PIX(L), .LINE_GAP(G)) i_color_line_aligner (
        .clk(clk), .rst(rst), .dir(dir), .pair_vld(pair_vld), .region(region),
        .red_odd(red_odd), .red_even(red_even), .grn_odd(grn_odd), .grn_even(grn_even),
        .blu_odd(blu_odd), .blu_even(blu_even),
        .out_vld(out_vld), .out_sol(out_sol), .out_r(out_r), .out_g(out_g), .out_b(out_b)
    );

    function automatic logic [15:0] enc(int c, int s, int p);
        return 16'((c << 12) | (s << 6) | p);
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Output monitor: every valid pixel is compared against its tag
    always @(negedge clk) begin
        if (!rst) begin
            if (out_sol && !out_vld) chk("R7 sol without vld", 1, 0);
            if (out_vld) begin
                int ln, p;
                ln = mon_idx / L;
                p  = mon_idx % L + 1;
                if (dir == 1'b0) begin
                    chk("R4 red",   out_r, enc(0, ln, p));
                    chk("R4 green", out_g, enc(1, ln + G, p));
                    chk("R4 blue",  out_b, enc(2, ln + LAG, p));
                end else begin
                    chk("R5 red",   out_r, enc(0, ln + LAG, p));
                    chk("R5 green", out_g, enc(1, ln + G, p));
                    chk("R5 blue",  out_b, enc(2, ln, p));
                end
                chk("R7 sol", out_sol, (mon_idx % L) == 0);
                if (mon_idx == 0 && !lat_done) begin
                    chk("R1 odd latency", cyc, cap_cyc + 1);
                    lat_done = 1;
                end
                mon_idx++;
            end
        end
    end

    task automatic send_pair(logic [1:0] rg, int s, int i, int gap);
        @(negedge clk);
        pair_vld = 1'b1;
        region   = rg;
        if (rg == 2'b10) begin
            red_odd = enc(0, s, 2*i+1); red_even = enc(0, s, 2*i+2);
            grn_odd = enc(1, s, 2*i+1); grn_even = enc(1, s, 2*i+2);
            blu_odd = enc(2, s, 2*i+1); blu_even = enc(2, s, 2*i+2);
        end else begin
            red_odd = 16'hFFF0; red_even = 16'hFFF1; grn_odd = 16'hFFF2;
            grn_even = 16'hFFF3; blu_odd = 16'hFFF4; blu_even = 16'hFFF5;
        end
        @(posedge clk);
        @(negedge clk);
        if (rg == 2'b10 && s == LAG && i == 0) cap_cyc = cyc;
        pair_vld = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    // R2: every line is wrapped in dummy, black and invalid pairs
    task automatic run_lines(int s0, int s1, int gap);
        for (int s = s0; s < s1; s++) begin
            for (int k = 0; k < 2; k++) send_pair(2'b00, s, k, gap);
            for (int k = 0; k < 3; k++) send_pair(2'b01, s, k, gap);
            for (int i = 0; i < L/2; i++) send_pair(2'b10, s, i, gap + (i % 2));
            for (int k = 0; k < 2; k++) send_pair(2'b11, s, k, gap);
        end
        repeat (6) @(negedge clk);
    endtask

    task automatic do_reset(logic d);
        @(negedge clk);
        rst = 1'b1;
        dir = d;
        repeat (3) @(negedge clk);
        mon_idx = 0;
        lat_done = 0;
        cap_cyc = -100;
        rst = 1'b0;
    endtask

    task automatic t_reset_state;
        do_reset(1'b0);
        @(negedge clk);
        chk("R6 reset vld", out_vld, 0);
        chk("R6 reset sol", out_sol, 0);
        chk("R6 reset data", {out_r, out_g, out_b} == '0, 1);
    endtask

    task automatic t_forward;
        do_reset(1'b0);
        run_lines(0, LAG + 4, 0);
        chk("R6 R2 output count dir0", mon_idx, 4 * L);
    endtask

    task automatic t_reverse;
        do_reset(1'b1);
        run_lines(0, LAG + 3, 2);
        chk("R6 R2 output count dir1", mon_idx, 3 * L);
    endtask

    task automatic t_dir_flip;
        @(negedge clk);
        dir = 1'b0;
        mon_idx = 0;
        lat_done = 0;
        cap_cyc = -100;
        run_lines(0, LAG, 1);
        chk("R8 blank after flip", mon_idx, 0);
        run_lines(LAG, LAG + 2, 1);
        chk("R8 count after flip", mon_idx, 2 * L);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset_state();
        t_forward();
        t_reverse();
        t_dir_flip();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
        $finish;
    end
endmodule